// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between a DRAM controller's command scheduler and the memory interface. Each cycle it decides whether the requested command may go out. It counts the cycles since three kinds of event: a granted refresh, a rise of the clock-enable line that ends self-refresh, and a rise that ends power-down. It refuses any command that would break a programmed spacing. The scheduler presents a request strobe, a 3-bit command code and the clock-enable level it drives. The guard answers with a combinational grant in the same cycle.

All delays come from one packed 32-bit timing word. Software reaches it through a plain write/read port. While a write-protect input is high, writes to the word are ignored. A memory-kind input selects SDR, DDR, low-power DDR1 or DDR2. That choice decides whether reads leaving self-refresh follow their own delay, and whether the power-down exit delay is enforced.

Command codes on `req_cmd`: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 self-refresh entry, 7 mode-register set. Memory-kind codes on `mem_kind`: 0 SDR, 1 DDR, 2 low-power DDR1, 3 DDR2.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset, the timing word reads 0x03C80808. In that word the refresh spacing (bits 4:0) is 8, the self-refresh-exit non-read delay (bits 15:8) is 8, the self-refresh-exit read delay (bits 23:16) is 200 and the power-down-exit delay (bits 27:24) is 3.
- R2: Bits 7:5 and 31:28 of the timing word always read as zero, whatever value is written to them.
- R3: A write presented while `wr_lock` is high leaves the timing word unchanged.
- R4: `grant` is high only when `req_valid` is high and `cke` is high. `grant` is low in the first cycle in which `cke` is seen high after being low.
- R5: After a refresh is granted, activate and refresh stay refused for exactly the refresh-spacing count of cycles. Other commands are not held back by this rule.
- R6: After `cke` rises to leave self-refresh, every non-read command stays refused in the rise cycle and for the non-read delay count of cycles that follow.
- R7: On DDR and DDR2, a read after self-refresh exit stays refused in the rise cycle and for the read delay count of cycles that follow. The non-read delay does not apply to it.
- R8: On SDR and low-power DDR1, a read after self-refresh exit follows the non-read delay instead.
- R9: On low-power DDR1 and DDR2, after `cke` rises to leave power-down (no self-refresh entry granted before `cke` fell), every command stays refused in the rise cycle and for the power-down-exit count of cycles that follow. On SDR and DDR, only the rise cycle is refused.
- R10: A programmed delay of zero lets the held-back command go out in the cycle right after the trigger cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_kind | input | 2 | Memory kind: 0 SDR, 1 DDR, 2 LP-DDR1, 3 DDR2 |
| req_valid | input | 1 | Scheduler requests a command this cycle |
| req_cmd | input | 3 | Command code of the request |
| cke | input | 1 | Clock-enable level driven to the memory |
| grant | output | 1 | Requested command may issue this cycle |
| reg_wr_en | input | 1 | Write strobe for the timing word |
| reg_wr_data | input | 32 | Write data for the timing word |
| wr_lock | input | 1 | Write protection; high blocks writes |
| reg_rd_data | output | 32 | Current timing word |

## Verification
A delay counter that loads the wrong value, or that misses its load, changes the number of cycles a held request waits before `grant` rises. The error therefore shows as a wait that is off by one or more cycles, at the first command after the trigger. A wrong self-refresh/power-down flag makes the wrong delay apply, so the wait length differs from the expected one within one exit sequence. A register fault shows on `reg_rd_data` in the cycle after the write.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int REG_W       = 32;
  localparam int RFC_LSB     = 0;
  localparam int RFC_W       = 5;
  localparam int XSNR_LSB    = 8;
  localparam int XSNR_W      = 8;
  localparam int XSRD_LSB    = 16;
  localparam int XSRD_W      = 8;
  localparam int XP_LSB      = 24;
  localparam int XP_W        = 4;
  localparam int CNT_W       = 8;
  localparam int NUM_CNT     = 4;

  localparam logic [RFC_W-1:0]  RFC_RST  = 5'd8;
  localparam logic [XSNR_W-1:0] XSNR_RST = 8'd8;
  localparam logic [XSRD_W-1:0] XSRD_RST = 8'd200;
  localparam logic [XP_W-1:0]   XP_RST   = 4'd3;

  // counter slots
  localparam int SLOT_RFC  = 0;
  localparam int SLOT_XSNR = 1;
  localparam int SLOT_XSRD = 2;
  localparam int SLOT_XP   = 3;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_SREF = 3'd6,
    CMD_MRS  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    MEM_SDR    = 2'd0,
    MEM_DDR    = 2'd1,
    MEM_LPDDR1 = 2'd2,
    MEM_DDR2   = 2'd3
  } mem_e;

  typedef struct packed {
    logic [XP_W-1:0]   xp;
    logic [XSRD_W-1:0] xsrd;
    logic [XSNR_W-1:0] xsnr;
    logic [RFC_W-1:0]  rfc;
  } timing_t;

endpackage

// File: rtl/dct_timing_reg.sv
module dct_timing_reg
  import dct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_lock,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output timing_t          fields
);

  timing_t fld_q, fld_nxt;
  logic    wr_ok;

  assign wr_ok = wr_en & ~wr_lock;

  always_comb begin
    fld_nxt = fld_q;
    if (wr_ok) begin
      fld_nxt.rfc  = wr_data[RFC_LSB  +: RFC_W];
      fld_nxt.xsnr = wr_data[XSNR_LSB +: XSNR_W];
      fld_nxt.xsrd = wr_data[XSRD_LSB +: XSRD_W];
      fld_nxt.xp   = wr_data[XP_LSB   +: XP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q.rfc  <= RFC_RST;
      fld_q.xsnr <= XSNR_RST;
      fld_q.xsrd <= XSRD_RST;
      fld_q.xp   <= XP_RST;
    end else if (wr_ok) begin
      fld_q <= fld_nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[RFC_LSB  +: RFC_W]  = fld_q.rfc;
    rd_data[XSNR_LSB +: XSNR_W] = fld_q.xsnr;
    rd_data[XSRD_LSB +: XSRD_W] = fld_q.xsrd;
    rd_data[XP_LSB   +: XP_W]   = fld_q.xp;
  end

  assign fields = fld_q;

endmodule

// File: rtl/dct_delay_cnt.sv
module dct_delay_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);

  logic [W-1:0] cnt_q, cnt_nxt;
  logic         cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = load | busy;

  always_comb begin
    if (load)      cnt_nxt = load_val;
    else if (busy) cnt_nxt = cnt_q - 1'b1;
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mem_kind,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic              cke,
  output logic              grant,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic              wr_lock,
  output logic [REG_W-1:0]  reg_rd_data
);

  timing_t fields;
  mem_e    mkind;
  cmd_e    cmd;

  logic                      cke_q;
  logic                      in_sref_q, in_sref_nxt;
  logic                      cke_rise;
  logic                      rd_own_rule, xp_rule;
  logic [NUM_CNT-1:0]        ld;
  logic [NUM_CNT-1:0]        busy;
  logic [NUM_CNT-1:0][CNT_W-1:0] ld_val;
  logic                      hold;

  assign mkind = mem_e'(mem_kind);
  assign cmd   = cmd_e'(req_cmd);

  dct_timing_reg u_treg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_lock (wr_lock),
    .wr_data (reg_wr_data),
    .rd_data (reg_rd_data),
    .fields  (fields)
  );

  assign cke_rise    = cke & ~cke_q;
  assign rd_own_rule = (mkind == MEM_DDR)    || (mkind == MEM_DDR2);
  assign xp_rule     = (mkind == MEM_LPDDR1) || (mkind == MEM_DDR2);

  // counter loads
  always_comb begin
    ld             = '0;
    ld_val         = '0;
    ld[SLOT_RFC]   = grant && (cmd == CMD_REF);
    ld[SLOT_XSNR]  = cke_rise & in_sref_q;
    ld[SLOT_XSRD]  = cke_rise & in_sref_q;
    ld[SLOT_XP]    = cke_rise & ~in_sref_q;
    ld_val[SLOT_RFC]  = CNT_W'(fields.rfc);
    ld_val[SLOT_XSNR] = CNT_W'(fields.xsnr);
    ld_val[SLOT_XSRD] = CNT_W'(fields.xsrd);
    ld_val[SLOT_XP]   = CNT_W'(fields.xp);
  end

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    dct_delay_cnt #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld[gi]),
      .load_val (ld_val[gi]),
      .busy     (busy[gi])
    );
  end

  // hold decision
  always_comb begin
    hold = ~cke | cke_rise;
    if (((cmd == CMD_ACT) || (cmd == CMD_REF)) && busy[SLOT_RFC]) hold = 1'b1;
    if (cmd == CMD_RD) begin
      if (rd_own_rule) begin
        if (busy[SLOT_XSRD]) hold = 1'b1;
      end else if (busy[SLOT_XSNR]) begin
        hold = 1'b1;
      end
    end else if (busy[SLOT_XSNR]) begin
      hold = 1'b1;
    end
    if (xp_rule && busy[SLOT_XP]) hold = 1'b1;
  end

  assign grant = req_valid & ~hold;

  always_comb begin
    in_sref_nxt = in_sref_q;
    if (cke_rise)                          in_sref_nxt = 1'b0;
    else if (grant && (cmd == CMD_SREF))   in_sref_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b1;
      in_sref_q <= 1'b0;
    end else begin
      cke_q     <= cke;
      in_sref_q <= in_sref_nxt;
    end
  end

endmodule

// File: rtl/dct_guard_chk.sv
module dct_guard_chk
  import dct_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_cmd,
  input logic             cke,
  input logic             grant,
  input logic             reg_wr_en,
  input logic             wr_lock,
  input logic [REG_W-1:0] reg_rd_data
);

  logic [6:0]       ref_age;
  logic             ref_seen;
  logic [RFC_W-1:0] rfc_cap;
  logic             ref_grant;

  assign ref_grant = grant && (req_cmd == CMD_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_age  <= '0;
      ref_seen <= 1'b0;
      rfc_cap  <= '0;
    end else if (ref_grant) begin
      ref_age  <= 7'd1;
      ref_seen <= 1'b1;
      rfc_cap  <= reg_rd_data[RFC_LSB +: RFC_W];
    end else if (ref_age != 7'h7f) begin
      ref_age  <= ref_age + 7'd1;
    end
  end

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> req_valid); // R4
  AST_NO_GRANT_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !grant); // R4
  AST_RISE_CYCLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !grant); // R4
  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && wr_lock) |=> $stable(reg_rd_data)); // R3
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[31:28] == 4'd0) && (reg_rd_data[7:5] == 3'd0)); // R2
  AST_REFRESH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && ref_seen && ((req_cmd == CMD_ACT) || (req_cmd == CMD_REF)))
      |-> (ref_age > 7'(rfc_cap))); // R5

endmodule

bind dram_cmd_guard dct_guard_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_cmd     (req_cmd),
  .cke         (cke),
  .grant       (grant),
  .reg_wr_en   (reg_wr_en),
  .wr_lock     (wr_lock),
  .reg_rd_data (reg_rd_data)
);

// File: tb/dram_cmd_guard_tb_top.sv
`timescale 1ns/1ps
module dram_cmd_guard_tb_top;

  localparam int C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_REF = 5, C_SREF = 6;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mem_kind;
  logic        req_valid;
  logic [2:0]  req_cmd;
  logic        cke;
  logic        grant;
  logic        reg_wr_en;
  logic [31:0] reg_wr_data;
  logic        wr_lock;
  logic [31:0] reg_rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dram_cmd_guard dut_i (
    .clk(clk), .rst_n(rst_n), .mem_kind(mem_kind), .req_valid(req_valid),
    .req_cmd(req_cmd), .cke(cke), .grant(grant), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .wr_lock(wr_lock), .reg_rd_data(reg_rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic reg_write(input logic [31:0] d);
    reg_wr_en   = 1'b1;
    reg_wr_data = d;
    tick();
    reg_wr_en   = 1'b0;
  endtask

  task automatic issue(input int c, output bit g);
    req_valid = 1'b1;
    req_cmd   = 3'(c);
    #1;
    g = grant;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic wait_count(input int c, output int n);
    req_valid = 1'b1;
    req_cmd   = 3'(c);
    n = 0;
    #1;
    while (!grant && n < 600) begin
      n++;
      tick();
      #1;
    end
    tick();
    req_valid = 1'b0;
  endtask

  task automatic sref_exit(input int c, output int n);
    bit g;
    issue(C_SREF, g);
    chk(g, "R6 sref entry grant", g, 1);
    cke = 1'b0;
    idle(3);
    cke = 1'b1;
    wait_count(c, n);
  endtask

  task automatic pd_exit(input int c, output int n);
    cke = 1'b0;
    idle(3);
    cke = 1'b1;
    wait_count(c, n);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit g;
    int n, exp_n;
    int rfc_set [5] = '{0, 1, 3, 7, 31};
    int s_set [3] = '{20, 2, 0};
    int d_set [3] = '{3, 9, 0};
    int p_set [3] = '{5, 0, 11};
    int cmds [3]  = '{C_RD, C_WR, C_ACT};

    rst_n = 1'b0; mem_kind = 2'd0; req_valid = 1'b0; req_cmd = 3'd0;
    cke = 1'b1; reg_wr_en = 1'b0; reg_wr_data = '0; wr_lock = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset word
    #1;
    chk(reg_rd_data == 32'h03C80808, "R1 reset value", reg_rd_data, 32'h03C80808);
    // R2 reserved bits read zero
    reg_write(32'hFFFF_FFFF);
    #1;
    chk(reg_rd_data == 32'h0FFF_FF1F, "R2 reserved masked", reg_rd_data, 32'h0FFFFF1F);
    // R3 locked write ignored
    wr_lock = 1'b1;
    reg_write(32'h0000_0000);
    #1;
    chk(reg_rd_data == 32'h0FFF_FF1F, "R3 locked write", reg_rd_data, 32'h0FFFFF1F);
    wr_lock = 1'b0;
    reg_write(32'h0000_0000);
    #1;
    chk(reg_rd_data == 32'h0, "R3 unlocked write", reg_rd_data, 0);

    // R4 no request, no grant; cke low blocks
    req_valid = 1'b0; req_cmd = 3'(C_WR);
    #1;
    chk(grant == 1'b0, "R4 grant without request", grant, 0);
    @(negedge clk);
    cke = 1'b0; req_valid = 1'b1; req_cmd = 3'(C_PRE);
    #1;
    chk(grant == 1'b0, "R4 grant while cke low", grant, 0);
    @(negedge clk);
    cke = 1'b1;
    #1;
    chk(grant == 1'b0, "R4 grant in rise cycle", grant, 0);
    @(negedge clk);
    #1;
    chk(grant == 1'b1, "R4 grant after rise (zero delays)", grant, 1);
    @(negedge clk);
    req_valid = 1'b0;
    idle(2);

    // R5 / R10 refresh spacing sweep
    foreach (rfc_set[i]) begin
      reg_write(32'(rfc_set[i]));
      idle(40);
      issue(C_REF, g);
      chk(g, "R5 refresh grant", g, 1);
      wait_count(C_ACT, n);
      chk(n == rfc_set[i], "R5 R10 refresh->activate", n, rfc_set[i]);
      idle(40);
      issue(C_REF, g);
      wait_count(C_REF, n);
      chk(n == rfc_set[i], "R5 refresh->refresh", n, rfc_set[i]);
      issue(C_PRE, g);
      chk(g, "R5 precharge not held", g, 1);
      idle(40);
      issue(C_REF, g);
      issue(C_WR, g);
      chk(g, "R5 write right after refresh", g, 1);
    end
    idle(40);

    // R6..R10 exit sweeps over memory kinds, parameter sets, commands
    for (int mk = 0; mk < 4; mk++) begin
      mem_kind = 2'(mk);
      foreach (s_set[k]) begin
        reg_write({4'd0, 4'(p_set[k]), 8'(d_set[k]), 8'(s_set[k]), 8'd0});
        foreach (cmds[j]) begin
          idle(30);
          sref_exit(cmds[j], n);
          if (cmds[j] == C_RD && (mk == 1 || mk == 3)) begin
            exp_n = d_set[k] + 1;
            chk(n == exp_n, "R7 R10 sref exit read own delay", n, exp_n);
          end else if (cmds[j] == C_RD) begin
            exp_n = s_set[k] + 1;
            chk(n == exp_n, "R8 R10 sref exit read non-read delay", n, exp_n);
          end else begin
            exp_n = s_set[k] + 1;
            chk(n == exp_n, "R6 R10 sref exit non-read", n, exp_n);
          end
          idle(30);
          pd_exit(cmds[j], n);
          exp_n = (mk == 2 || mk == 3) ? p_set[k] + 1 : 1;
          chk(n == exp_n, "R9 R10 power-down exit", n, exp_n);
        end
      end
    end

    // R7 default timing word on DDR
    mem_kind = 2'd1;
    reg_write(32'h03C80808);
    idle(30);
    sref_exit(C_RD, n);
    chk(n == 201, "R7 default read delay", n, 201);
    idle(250);
    sref_exit(C_WR, n);
    chk(n == 9, "R6 default non-read delay", n, 9);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule